// File: doc/BRIEF.md
# Variable-Length Multi-Bit Shift Register

This block holds a bit register of up to `MAXLEN` bits, 1024 by default, and shifts a window of it left by several positions in one operation. The window always starts at bit 0. Its length `len` and the shift step `step` are inputs that may change from one operation to the next.

One operation does three things at once. It drops the top `step` bits of the window and shows them on `ovf`. It moves the remaining window bits up by `step`. It fills the `step` freed low positions from the `src` input, with `src[i]` going to bit `i`. Bits at or above `len` are never touched.

The `cmd` input starts an operation, and `mode` selects how. With `mode` = 0 (pulse) there is one operation per rising edge of `cmd`. With `mode` = 1 (continuous) there is one operation on every clock cycle while `cmd` is high.

Two faults are reported, and either one blocks the shift. Bad lengths raise a parameter error. An `overlap` input, meaning that the source bits are the destination bits, raises an operation error with code 6710.

Top module: `varlen_shift_reg`

## Requirements
- R1: While `rst` is high at a clock edge, `q`, `ovf`, `done`, `par_err` and `op_err` all become 0, and the edge detector is cleared so that `cmd` counts as previously low.
- R2: An operation that fires at a clock edge with valid lengths and `overlap` = 0 sets bit `i` of `q` as follows, for every `i` below `len`: `src[i]` when `i` is below `step`, and otherwise the old value of bit `i-step`. The new value is visible after that same edge.
- R3: `done` is high for exactly the one cycle after each completed shift. During that cycle, `ovf[i]` holds the old bit `len-step+i` for each `i` below `step`, and all other `ovf` bits are 0. While `done` is low, `ovf` is all 0.
- R4: No shift modifies a bit of `q` at index `len` or above.
- R5: With `mode` = 0, an operation fires only at an edge where `cmd` is 1 and `cmd` was 0 at the previous edge. Holding `cmd` high gives exactly one operation.
- R6: With `mode` = 1, an operation fires at every edge where `cmd` is 1.
- R7: A fired operation with `len` = 0, `step` = 0, `step` > `len`, or `len` > `MAXLEN` sets `par_err` to 1 and `op_err` to 0. It leaves `q` unchanged and gives no `done` pulse. This check takes priority over the overlap check.
- R8: A fired operation with valid lengths and `overlap` = 1 sets `op_err` to 1 and `par_err` to 0. It leaves `q` unchanged and gives no `done` pulse. `err_code` reads 6710 while `op_err` is 1 and 0 otherwise.
- R9: `par_err` and `op_err` keep the result of the most recent fired operation until the next one fires. A completed shift clears both flags.
- R10: At an edge where no operation fires, `q` and both error flags keep their values and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one operation cycle |
| rst | input | 1 | Synchronous active-high reset |
| len | input | LW | Window length in bits, starting at bit 0 |
| step | input | LW | Number of positions to shift and bits to fill |
| src | input | MAXLEN | Fill bits; `src[i]` lands in bit `i` |
| cmd | input | 1 | Command input |
| mode | input | 1 | 0 = one operation per rising edge of `cmd`, 1 = every cycle while `cmd` is high |
| overlap | input | 1 | Source and destination overlap; blocks the shift |
| q | output | MAXLEN | Register contents |
| ovf | output | MAXLEN | Bits discarded by the last shift, valid while `done` is high |
| done | output | 1 | One-cycle pulse after a completed shift |
| par_err | output | 1 | Length or step out of range on the last fired operation |
| op_err | output | 1 | Overlap fault on the last fired operation |
| err_code | output | 16 | 6710 while `op_err` is high, otherwise 0 |

## Verification
Each fault in this block shows at the ports within one cycle of the operation that exposes it:
- A wrong window mask corrupts `q` above `len`, or leaves low bits unfilled, on the very next sample.
- An off-by-one in the overflow offset shows as a wrong `ovf` word during the `done` cycle.
- A broken edge detector in pulse mode shows as extra `done` pulses while `cmd` is held high.
- A missing length check shows as a shift and a `done` pulse where `par_err` should have been set with `q` frozen.

The sweep visits every pair of `len` and `step` from 0 to `MAXLEN`+1 in a small configuration, so each boundary of the valid range is reached.

// File: rtl/varlen_shift_reg.sv
module varlen_shift_reg #(
  parameter int MAXLEN = 1024,
  parameter int LW = $clog2(MAXLEN + 1),
  parameter logic [15:0] OVL_CODE = 16'd6710
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LW-1:0]     len,
  input  logic [LW-1:0]     step,
  input  logic [MAXLEN-1:0] src,
  input  logic              cmd,
  input  logic              mode,
  input  logic              overlap,
  output logic [MAXLEN-1:0] q,
  output logic [MAXLEN-1:0] ovf,
  output logic              done,
  output logic              par_err,
  output logic              op_err,
  output logic [15:0]       err_code
);
  localparam logic [MAXLEN-1:0] ONES = {MAXLEN{1'b1}};
  localparam logic [LW-1:0] LMAX = LW'(MAXLEN);

  logic cmd_q, fire, bad;
  logic [MAXLEN-1:0] win_mask, fill_mask, win, q_next, ovf_next;

  assign fire      = cmd & (mode | ~cmd_q);
  assign bad       = (len == '0) || (step == '0) || (step > len) || (len > LMAX);
  assign win_mask  = ~(ONES << len);
  assign fill_mask = ~(ONES << step);
  assign win       = q & win_mask;
  assign q_next    = (q & ~win_mask) | ((win << step) & win_mask) | (src & fill_mask);
  assign ovf_next  = (win >> (len - step)) & fill_mask;
  assign err_code  = op_err ? OVL_CODE : 16'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= 1'b0;
      q       <= '0;
      ovf     <= '0;
      done    <= 1'b0;
      par_err <= 1'b0;
      op_err  <= 1'b0;
    end else begin
      cmd_q <= cmd;
      done  <= 1'b0;
      ovf   <= '0;
      if (fire) begin
        if (bad) begin
          par_err <= 1'b1;
          op_err  <= 1'b0;
        end else if (overlap) begin
          par_err <= 1'b0;
          op_err  <= 1'b1;
        end else begin
          par_err <= 1'b0;
          op_err  <= 1'b0;
          q       <= q_next;
          ovf     <= ovf_next;
          done    <= 1'b1;
        end
      end
    end
  end

  // R10: no command, no change
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !cmd |=> ($stable(q) && !done && $stable(par_err) && $stable(op_err)));
  // R3: overflow word only during done
  p_ovf_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !done |-> (ovf == '0));
  // R5: pulse mode never gives back-to-back shifts
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> $past(mode));
  // R7: a parameter error freezes the register
  p_par_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(par_err) |-> ($stable(q) && !done));
  // R8: an overlap error freezes the register
  p_ovl_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(op_err) |-> ($stable(q) && !done));
  // R9: at most one outcome per operation
  p_outcome_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, par_err, op_err}));
  // R8: code follows flag
  p_code_r8: assert property (@(posedge clk) disable iff (rst)
    op_err |-> (err_code == OVL_CODE));
endmodule

// File: tb/test_varlen_shift_reg.sv
module test_varlen_shift_reg;
  localparam int N = 16;
  localparam int LW = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic [LW-1:0] len = '0, step = '0;
  logic [N-1:0] src = '0;
  logic cmd = 1'b0, mode = 1'b0, overlap = 1'b0;
  logic [N-1:0] q, ovf;
  logic done, par_err, op_err;
  logic [15:0] err_code;

  int checks = 0, errors = 0;
  logic [N-1:0] eq = '0, eovf;
  logic epar = 1'b0, eop = 1'b0, edone;

  always #4 clk = ~clk;

  varlen_shift_reg #(.MAXLEN(N), .LW(LW)) i_varlen_shift_reg (
    .clk(clk), .rst(rst), .len(len), .step(step), .src(src), .cmd(cmd),
    .mode(mode), .overlap(overlap), .q(q), .ovf(ovf), .done(done),
    .par_err(par_err), .op_err(op_err), .err_code(err_code));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(q == eq, {tag, " q"}, 32'(q), 32'(eq));
    chk(ovf == eovf, {tag, " ovf"}, 32'(ovf), 32'(eovf));
    chk(done == edone, {tag, " done"}, 32'(done), 32'(edone));
    chk(par_err == epar, {tag, " par_err"}, 32'(par_err), 32'(epar));
    chk(op_err == eop, {tag, " op_err"}, 32'(op_err), 32'(eop));
    chk(err_code == (eop ? 16'd6710 : 16'd0), {tag, " err_code R8"}, 32'(err_code), eop ? 32'd6710 : 32'd0);
  endtask

  task automatic model(input int l, input int s, input logic [N-1:0] sv, input logic ov);
    logic [N-1:0] nq;
    eovf = '0;
    edone = 1'b0;
    if (l < 1 || s < 1 || s > l || l > N) begin
      epar = 1'b1; eop = 1'b0;
    end else if (ov) begin
      epar = 1'b0; eop = 1'b1;
    end else begin
      epar = 1'b0; eop = 1'b0; edone = 1'b1;
      nq = eq;
      for (int i = 0; i < l; i++) nq[i] = (i < s) ? sv[i] : eq[i - s];
      for (int i = 0; i < s; i++) eovf[i] = eq[l - s + i];
      eq = nq;
    end
  endtask

  task automatic do_op(input int l, input int s, input logic [N-1:0] sv, input logic ov, input logic md, input string tag);
    @(negedge clk);
    len = LW'(l); step = LW'(s); src = sv; overlap = ov; mode = md; cmd = 1'b1;
    @(negedge clk);
    cmd = 1'b0;
    model(l, s, sv, ov);
    compare(tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] pat;
    cmd = 1'b1;
    repeat (3) @(negedge clk);
    cmd = 1'b0;
    eovf = '0; edone = 1'b0;
    compare("R1 reset");
    rst = 1'b0;

    for (int l = 0; l <= N + 1; l++) begin
      for (int s = 0; s <= N + 1; s++) begin
        pat = N'((l * 16'h9e37) ^ (s * 16'h5a5b) ^ 16'hc3a5);
        do_op(N, N, pat, 1'b0, 1'b1, "R2 load");
        do_op(l, s, ~pat ^ N'(l * 31 + s), ((l + s) % 5) == 0, (l + s) % 2 == 1, "R2 R3 R4 R7 R8 sweep");
        @(negedge clk);
        edone = 1'b0; eovf = '0;
        compare("R10 R9 idle");
      end
    end

    do_op(12, 3, 16'h0005, 1'b0, 1'b0, "R2 setup");
    do_op(12, 3, 16'h0002, 1'b1, 1'b0, "R8 overlap");
    do_op(0, 3, 16'h0002, 1'b1, 1'b0, "R7 priority");
    do_op(12, 3, 16'h0006, 1'b0, 1'b0, "R9 clear");

    @(negedge clk);
    len = 5'd8; step = 5'd2; src = 16'h0003; overlap = 1'b0; mode = 1'b0; cmd = 1'b1;
    @(negedge clk);
    model(8, 2, 16'h0003, 1'b0);
    compare("R5 first");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      edone = 1'b0; eovf = '0;
      compare("R5 held");
    end
    cmd = 1'b0;

    @(negedge clk);
    len = 5'd10; step = 5'd3; src = 16'h0005; mode = 1'b1; cmd = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      model(10, 3, 16'h0005, 1'b0);
      compare("R6 held");
    end
    cmd = 1'b0;
    @(negedge clk);
    edone = 1'b0; eovf = '0;
    compare("R10 after R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule